// File: doc/BRIEF.md
# Variable-Page Translation Lookaside Buffer

This block translates a 32-bit effective address into a real address using a small table of entries that are all searched at once. Any translation may sit in any slot, and every slot carries its own page size, chosen from nine sizes that grow by a factor of four from 4 KB up to 256 MB. A slot's size decides how many upper address bits take part in the tag compare and how many low bits pass straight through as the page offset. The access permissions and the memory attribute bits of the matching slot are returned along with the translated address.

A lookup presents an effective address, a process number, an access kind and a privilege level. One clock later the block reports hit or miss, the real address, the slot's permission and attribute bits, whether the access breaks those permissions, and whether more than one slot matched. Maintenance software installs or removes one slot per write, addressed by index, and can drop every translation in a single cycle.

Top module: `vpage_tlb`

## Requirements
- R1: Reset clears every slot's valid bit and all result outputs; a lookup after reset misses.
- R2: A write with `wr_en` high stores the full slot contents at `wr_idx` on the next clock edge; a lookup issued in the same cycle as the write sees the slot contents from before the write.
- R3: The size code is 4 bits: code s in 1..9 gives a page of 2^(12+2*(s-1)) bytes, and the slot matches when effective address bits [31:12+2*(s-1)] equal the same bits of the stored tag; codes 0 and 10..15 never match.
- R4: On a hit, real address bits below 12+2*(s-1) come from the effective address and the bits at and above come from the slot's stored real page number.
- R5: A slot whose stored process number is 0 matches any request; any other stored value matches only an equal request process number (a request number of 0 is not a wildcard).
- R6: `rs_valid` is high exactly one cycle after `lk_req`; with it exactly one of `rs_hit` and `rs_miss` is high; without a request all flags are low; on a miss the address, permission and attribute outputs are zero.
- R7: When several slots match, the lowest-numbered one supplies the result and `rs_multi` is high; with a single match `rs_multi` is low.
- R8: Permission bits are [5] supervisor read, [4] supervisor write, [3] supervisor execute, [2] user read, [1] user write, [0] user execute; access code 0 is read, 1 write, 2 execute, 3 is never allowed; `rs_viol` is high on a hit whose access is not allowed at the requested privilege (`lk_super` high selects the supervisor bits).
- R9: On a hit `rs_attr` and `rs_perm` equal the matching slot's stored attribute and permission fields.
- R10: `inv_all` clears every valid bit on the next clock edge, taking priority over a write of valid data in the same cycle (the other fields of that write are still stored).
- R11: A write with `wr_valid` low removes the addressed slot so that its page then misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_ea | input | 32 | Effective address to translate |
| lk_pid | input | 8 | Requesting process number |
| lk_acc | input | 2 | Access kind: 0 read, 1 write, 2 execute, 3 reserved |
| lk_super | input | 1 | Supervisor privilege when high |
| wr_en | input | 1 | Slot write strobe |
| wr_idx | input | 5 | Slot index to write |
| wr_valid | input | 1 | Valid bit for the written slot |
| wr_pid | input | 8 | Process number for the slot (0 = any) |
| wr_size | input | 4 | Page size code |
| wr_epn | input | 20 | Effective page tag, address bits [31:12] |
| wr_rpn | input | 20 | Real page number, address bits [31:12] |
| wr_perm | input | 6 | Permission bits |
| wr_attr | input | 5 | Memory attribute bits |
| inv_all | input | 1 | Clear all valid bits |
| rs_valid | output | 1 | Result present |
| rs_hit | output | 1 | A slot matched |
| rs_miss | output | 1 | No slot matched |
| rs_multi | output | 1 | More than one slot matched |
| rs_ra | output | 32 | Real address |
| rs_perm | output | 6 | Permission bits of the chosen slot |
| rs_attr | output | 5 | Attribute bits of the chosen slot |
| rs_viol | output | 1 | Access not allowed by the chosen slot |

## Verification
On every cycle the assertions check the result timing against the request, the exclusivity of hit and miss, that multi-match and violation flags never appear without a hit, that the page offset of a hit is the request's own low bits, and that a lookup right after a full invalidate misses. Which slot wins, the masked compare at each of the nine sizes and the rejected codes, process-number matching, the permission decode and same-cycle write ordering depend on stored contents, so only the bench scenarios show them. The bench sweeps every size code against in-page and out-of-page probes and every permission pattern against every access kind and privilege.

// File: rtl/vpage_tlb_pkg.sv
package vpage_tlb_pkg;

   localparam int PERM_W = 6;

   typedef enum logic [1:0] {
      ACC_LOAD  = 2'd0,
      ACC_STORE = 2'd1,
      ACC_FETCH = 2'd2,
      ACC_RSVD  = 2'd3
   } vpt_acc_e;

   // perm[5:3] supervisor r/w/x, perm[2:0] user r/w/x
   function automatic logic perm_allows(input logic [PERM_W-1:0] perm,
                                        input logic [1:0] acc,
                                        input logic sup);
      logic [2:0] rwx;
      rwx = sup ? perm[5:3] : perm[2:0];
      case (vpt_acc_e'(acc))
         ACC_LOAD:  return rwx[2];
         ACC_STORE: return rwx[1];
         ACC_FETCH: return rwx[0];
         default:   return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/vpage_tlb_entry.sv
module vpage_tlb_entry #(
   parameter int PN_W      = 20,
   parameter int PID_W     = 8,
   parameter int PERM_W    = 6,
   parameter int ATTR_W    = 5,
   parameter int SIZE_W    = 4,
   parameter int NUM_SIZES = 9,
   parameter int SIZE_STEP = 2,
   parameter bit ENABLE_PID = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic              inv_all,
   input  logic              wr_valid,
   input  logic [PID_W-1:0]  wr_pid,
   input  logic [SIZE_W-1:0] wr_size,
   input  logic [PN_W-1:0]   wr_epn,
   input  logic [PN_W-1:0]   wr_rpn,
   input  logic [PERM_W-1:0] wr_perm,
   input  logic [ATTR_W-1:0] wr_attr,
   input  logic [PN_W-1:0]   lk_pn,
   input  logic [PID_W-1:0]  lk_pid,
   output logic              match,
   output logic [PN_W-1:0]   ra_pn,
   output logic [PERM_W-1:0] perm,
   output logic [ATTR_W-1:0] attr
);

   logic              valid_q;
   logic [PID_W-1:0]  pid_q;
   logic [SIZE_W-1:0] size_q;
   logic [PN_W-1:0]   epn_q;
   logic [PN_W-1:0]   rpn_q;
   logic [PERM_W-1:0] perm_q;
   logic [ATTR_W-1:0] attr_q;

   logic              size_ok;
   logic              pid_ok;
   logic [PN_W-1:0]   pn_mask;   // 1 = bit belongs to the page number

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         pid_q   <= '0;
         size_q  <= '0;
         epn_q   <= '0;
         rpn_q   <= '0;
         perm_q  <= '0;
         attr_q  <= '0;
      end else begin
         if (we) begin
            pid_q  <= wr_pid;
            size_q <= wr_size;
            epn_q  <= wr_epn;
            rpn_q  <= wr_rpn;
            perm_q <= wr_perm;
            attr_q <= wr_attr;
         end
         if (inv_all)
            valid_q <= 1'b0;
         else if (we)
            valid_q <= wr_valid;
      end
   end

   always_comb begin
      int sh;
      size_ok = (size_q != '0) && (int'(size_q) <= NUM_SIZES);
      sh = SIZE_STEP * (int'(size_q) - 1);
      for (int j = 0; j < PN_W; j++)
         pn_mask[j] = (j >= sh);
   end

   if (ENABLE_PID) begin : g_pid
      assign pid_ok = (pid_q == '0) || (pid_q == lk_pid);
   end else begin : g_nopid
      assign pid_ok = 1'b1;
   end

   assign match = valid_q && size_ok && pid_ok && (((lk_pn ^ epn_q) & pn_mask) == '0);
   assign ra_pn = (rpn_q & pn_mask) | (lk_pn & ~pn_mask);
   assign perm  = perm_q;
   assign attr  = attr_q;

endmodule

// File: rtl/vpage_tlb_select.sv
module vpage_tlb_select #(
   parameter int N     = 32,
   parameter int IDX_W = $clog2(N)
) (
   input  logic [N-1:0]     match,
   output logic             any,
   output logic             multi,
   output logic [IDX_W-1:0] idx
);

   always_comb begin
      any   = 1'b0;
      multi = 1'b0;
      idx   = '0;
      for (int i = N - 1; i >= 0; i--)
         if (match[i]) idx = IDX_W'(i);
      for (int i = 0; i < N; i++)
         if (match[i]) begin
            if (any) multi = 1'b1;
            any = 1'b1;
         end
   end

endmodule

// File: rtl/vpage_tlb.sv
module vpage_tlb
   import vpage_tlb_pkg::*;
#(
   parameter int N_ENTRIES     = 32,
   parameter int EA_W          = 32,
   parameter int MIN_PAGE_LOG2 = 12,
   parameter int NUM_SIZES     = 9,
   parameter int SIZE_STEP     = 2,
   parameter int SIZE_W        = 4,
   parameter int PID_W         = 8,
   parameter int ATTR_W        = 5,
   parameter bit ENABLE_PID    = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          lk_req,
   input  logic [EA_W-1:0]               lk_ea,
   input  logic [PID_W-1:0]              lk_pid,
   input  logic [1:0]                    lk_acc,
   input  logic                          lk_super,
   input  logic                          wr_en,
   input  logic [$clog2(N_ENTRIES)-1:0]  wr_idx,
   input  logic                          wr_valid,
   input  logic [PID_W-1:0]              wr_pid,
   input  logic [SIZE_W-1:0]             wr_size,
   input  logic [EA_W-MIN_PAGE_LOG2-1:0] wr_epn,
   input  logic [EA_W-MIN_PAGE_LOG2-1:0] wr_rpn,
   input  logic [5:0]                    wr_perm,
   input  logic [ATTR_W-1:0]             wr_attr,
   input  logic                          inv_all,
   output logic                          rs_valid,
   output logic                          rs_hit,
   output logic                          rs_miss,
   output logic                          rs_multi,
   output logic [EA_W-1:0]               rs_ra,
   output logic [5:0]                    rs_perm,
   output logic [ATTR_W-1:0]             rs_attr,
   output logic                          rs_viol
);

   localparam int PN_W  = EA_W - MIN_PAGE_LOG2;
   localparam int IDX_W = $clog2(N_ENTRIES);
   localparam int MAX_OFFSET_LOG2 = MIN_PAGE_LOG2 + SIZE_STEP * (NUM_SIZES - 1);

   if (N_ENTRIES < 2) begin : g_bad_entries
      $error("vpage_tlb: N_ENTRIES must be at least 2");
   end
   if (MAX_OFFSET_LOG2 >= EA_W) begin : g_bad_pages
      $error("vpage_tlb: largest page does not fit the address width");
   end
   if (NUM_SIZES >= (1 << SIZE_W)) begin : g_bad_codes
      $error("vpage_tlb: size field too narrow for the page sizes");
   end
   if (PERM_W != 6) begin : g_bad_perm
      $error("vpage_tlb: permission width must be 6");
   end

   logic [N_ENTRIES-1:0] ent_match;
   logic [PN_W-1:0]      ent_pn   [N_ENTRIES];
   logic [PERM_W-1:0]    ent_perm [N_ENTRIES];
   logic [ATTR_W-1:0]    ent_attr [N_ENTRIES];

   for (genvar e = 0; e < N_ENTRIES; e++) begin : g_ent
      vpage_tlb_entry #(
         .PN_W       (PN_W),
         .PID_W      (PID_W),
         .PERM_W     (PERM_W),
         .ATTR_W     (ATTR_W),
         .SIZE_W     (SIZE_W),
         .NUM_SIZES  (NUM_SIZES),
         .SIZE_STEP  (SIZE_STEP),
         .ENABLE_PID (ENABLE_PID)
      ) u_ent (
         .clk      (clk),
         .rst_n    (rst_n),
         .we       (wr_en && (wr_idx == IDX_W'(e))),
         .inv_all  (inv_all),
         .wr_valid (wr_valid),
         .wr_pid   (wr_pid),
         .wr_size  (wr_size),
         .wr_epn   (wr_epn),
         .wr_rpn   (wr_rpn),
         .wr_perm  (wr_perm),
         .wr_attr  (wr_attr),
         .lk_pn    (lk_ea[EA_W-1:MIN_PAGE_LOG2]),
         .lk_pid   (lk_pid),
         .match    (ent_match[e]),
         .ra_pn    (ent_pn[e]),
         .perm     (ent_perm[e]),
         .attr     (ent_attr[e])
      );
   end

   logic             sel_any;
   logic             sel_multi;
   logic [IDX_W-1:0] sel_idx;

   vpage_tlb_select #(
      .N     (N_ENTRIES),
      .IDX_W (IDX_W)
   ) u_sel (
      .match (ent_match),
      .any   (sel_any),
      .multi (sel_multi),
      .idx   (sel_idx)
   );

   logic              take_hit;
   logic [PN_W-1:0]   sel_pn;
   logic [PERM_W-1:0] sel_perm;
   logic [ATTR_W-1:0] sel_attr;
   logic              sel_allow;

   always_comb begin
      take_hit  = lk_req && sel_any;
      sel_pn    = ent_pn[sel_idx];
      sel_perm  = ent_perm[sel_idx];
      sel_attr  = ent_attr[sel_idx];
      sel_allow = perm_allows(sel_perm, lk_acc, lk_super);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_multi <= 1'b0;
         rs_ra    <= '0;
         rs_perm  <= '0;
         rs_attr  <= '0;
         rs_viol  <= 1'b0;
      end else begin
         rs_valid <= lk_req;
         rs_hit   <= take_hit;
         rs_miss  <= lk_req && !sel_any;
         rs_multi <= take_hit && sel_multi;
         rs_ra    <= take_hit ? {sel_pn, lk_ea[MIN_PAGE_LOG2-1:0]} : '0;
         rs_perm  <= take_hit ? sel_perm : '0;
         rs_attr  <= take_hit ? sel_attr : '0;
         rs_viol  <= take_hit && !sel_allow;
      end
   end

endmodule

// File: rtl/vpage_tlb_chk.sv
module vpage_tlb_chk #(
   parameter int EA_W          = 32,
   parameter int MIN_PAGE_LOG2 = 12
) (
   input logic            clk,
   input logic            rst_n,
   input logic            lk_req,
   input logic [EA_W-1:0] lk_ea,
   input logic            inv_all,
   input logic            rs_valid,
   input logic            rs_hit,
   input logic            rs_miss,
   input logic            rs_multi,
   input logic [EA_W-1:0] rs_ra,
   input logic            rs_viol
);

   p_result_next_r6: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> rs_valid && ($countones({rs_hit, rs_miss}) == 1));

   p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_req |=> !rs_valid && !rs_hit && !rs_miss && !rs_multi && !rs_viol);

   p_multi_needs_hit_r7: assert property (@(posedge clk) disable iff (!rst_n)
      rs_multi |-> rs_hit);

   p_viol_needs_hit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rs_viol |-> rs_hit);

   p_offset_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
      lk_req |=> (rs_miss || (rs_ra[MIN_PAGE_LOG2-1:0] == $past(lk_ea[MIN_PAGE_LOG2-1:0]))));

   p_flush_misses_r10: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all ##1 lk_req |=> rs_miss);

endmodule

bind vpage_tlb vpage_tlb_chk #(
   .EA_W          (EA_W),
   .MIN_PAGE_LOG2 (MIN_PAGE_LOG2)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_req   (lk_req),
   .lk_ea    (lk_ea),
   .inv_all  (inv_all),
   .rs_valid (rs_valid),
   .rs_hit   (rs_hit),
   .rs_miss  (rs_miss),
   .rs_multi (rs_multi),
   .rs_ra    (rs_ra),
   .rs_viol  (rs_viol)
);

// File: tb/vpage_tlb_tb.sv
`timescale 1ns/1ps
module vpage_tlb_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_req;
   logic [31:0] lk_ea;
   logic [7:0]  lk_pid;
   logic [1:0]  lk_acc;
   logic        lk_super;
   logic        wr_en;
   logic [4:0]  wr_idx;
   logic        wr_valid;
   logic [7:0]  wr_pid;
   logic [3:0]  wr_size;
   logic [19:0] wr_epn;
   logic [19:0] wr_rpn;
   logic [5:0]  wr_perm;
   logic [4:0]  wr_attr;
   logic        inv_all;
   logic        rs_valid, rs_hit, rs_miss, rs_multi, rs_viol;
   logic [31:0] rs_ra;
   logic [5:0]  rs_perm;
   logic [4:0]  rs_attr;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vpage_tlb u_dut (
      .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_ea(lk_ea), .lk_pid(lk_pid),
      .lk_acc(lk_acc), .lk_super(lk_super), .wr_en(wr_en), .wr_idx(wr_idx),
      .wr_valid(wr_valid), .wr_pid(wr_pid), .wr_size(wr_size), .wr_epn(wr_epn),
      .wr_rpn(wr_rpn), .wr_perm(wr_perm), .wr_attr(wr_attr), .inv_all(inv_all),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_multi(rs_multi),
      .rs_ra(rs_ra), .rs_perm(rs_perm), .rs_attr(rs_attr), .rs_viol(rs_viol)
   );

   // bench-side table of what has been installed
   logic        m_valid [32];
   logic [7:0]  m_pid   [32];
   logic [3:0]  m_size  [32];
   logic [19:0] m_epn   [32];
   logic [19:0] m_rpn   [32];
   logic [5:0]  m_perm  [32];
   logic [4:0]  m_attr  [32];

   task automatic m_write(input int idx, input logic v, input logic [7:0] pid,
                          input logic [3:0] sz, input logic [19:0] epn, input logic [19:0] rpn,
                          input logic [5:0] pm, input logic [4:0] at);
      m_valid[idx] = v; m_pid[idx] = pid; m_size[idx] = sz;
      m_epn[idx] = epn; m_rpn[idx] = rpn; m_perm[idx] = pm; m_attr[idx] = at;
   endtask

   task automatic model_look(input logic [31:0] ea, input logic [7:0] pid,
                             input logic [1:0] acc, input logic sup,
                             output logic hit, output logic multi, output logic [31:0] ra,
                             output logic [5:0] pm, output logic [4:0] at, output logic vi);
      int first;
      int cnt;
      int pl;
      int fpl;
      int bitn;
      logic [31:0] lowm;
      first = -1; cnt = 0; fpl = 12;
      for (int e = 0; e < 32; e++) begin
         if (m_valid[e] && m_size[e] >= 4'd1 && m_size[e] <= 4'd9 &&
             (m_pid[e] == 8'd0 || m_pid[e] == pid)) begin
            pl = 12 + 2 * (int'(m_size[e]) - 1);
            if ((ea >> pl) == ({m_epn[e], 12'h000} >> pl)) begin
               cnt++;
               if (first < 0) begin first = e; fpl = pl; end
            end
         end
      end
      hit = (first >= 0);
      multi = hit && (cnt > 1);
      if (hit) begin
         lowm = (32'd1 << fpl) - 32'd1;
         ra = ({m_rpn[first], 12'h000} & ~lowm) | (ea & lowm);
         pm = m_perm[first];
         at = m_attr[first];
         if (acc == 2'd3) vi = 1'b1;
         else begin
            bitn = sup ? (5 - int'(acc)) : (2 - int'(acc));
            vi = !m_perm[first][bitn];
         end
      end else begin
         ra = '0; pm = '0; at = '0; vi = 1'b0;
      end
   endtask

   task automatic compare(input string tag, input logic hit, input logic multi,
                          input logic [31:0] ra, input logic [5:0] pm,
                          input logic [4:0] at, input logic vi);
      checks++;
      if (rs_valid !== 1'b1 || rs_hit !== hit || rs_miss !== !hit || rs_multi !== multi ||
          rs_ra !== ra || rs_perm !== pm || rs_attr !== at || rs_viol !== vi) begin
         failures++;
         $display("FAIL %s: got v=%b h=%b m=%b mh=%b ra=%h pm=%h at=%h vi=%b exp v=1 h=%b m=%b mh=%b ra=%h pm=%h at=%h vi=%b",
                  tag, rs_valid, rs_hit, rs_miss, rs_multi, rs_ra, rs_perm, rs_attr, rs_viol,
                  hit, !hit, multi, ra, pm, at, vi);
      end
   endtask

   task automatic check_idle(input string tag);
      checks++;
      if (rs_valid !== 1'b0 || rs_hit !== 1'b0 || rs_miss !== 1'b0 || rs_multi !== 1'b0 ||
          rs_viol !== 1'b0 || rs_ra !== 32'd0) begin
         failures++;
         $display("FAIL %s: idle outputs got v=%b h=%b m=%b mh=%b vi=%b ra=%h exp all zero",
                  tag, rs_valid, rs_hit, rs_miss, rs_multi, rs_viol, rs_ra);
      end
   endtask

   task automatic drive_write(input int idx, input logic v, input logic [7:0] pid,
                              input logic [3:0] sz, input logic [19:0] epn, input logic [19:0] rpn,
                              input logic [5:0] pm, input logic [4:0] at);
      wr_en = 1'b1; wr_idx = 5'(idx); wr_valid = v; wr_pid = pid; wr_size = sz;
      wr_epn = epn; wr_rpn = rpn; wr_perm = pm; wr_attr = at;
   endtask

   task automatic do_write(input int idx, input logic v, input logic [7:0] pid,
                           input logic [3:0] sz, input logic [19:0] epn, input logic [19:0] rpn,
                           input logic [5:0] pm, input logic [4:0] at);
      @(negedge clk);
      drive_write(idx, v, pid, sz, epn, rpn, pm, at);
      @(negedge clk);
      wr_en = 1'b0;
      m_write(idx, v, pid, sz, epn, rpn, pm, at);
   endtask

   task automatic do_look(input logic [31:0] ea, input logic [7:0] pid,
                          input logic [1:0] acc, input logic sup, input string tag);
      logic h, mh, vi;
      logic [31:0] ra;
      logic [5:0] pm;
      logic [4:0] at;
      @(negedge clk);
      lk_req = 1'b1; lk_ea = ea; lk_pid = pid; lk_acc = acc; lk_super = sup;
      model_look(ea, pid, acc, sup, h, mh, ra, pm, at, vi);
      @(negedge clk);
      lk_req = 1'b0;
      compare(tag, h, mh, ra, pm, at, vi);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      for (int e = 0; e < 32; e++) m_valid[e] = 1'b0;
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: got timeout exp completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] base, ea_in, ea_out, ea_hi;
      logic h, mh, vi;
      logic [31:0] ra;
      logic [5:0] pm;
      logic [4:0] at;
      int pl;

      rst_n = 1'b0; lk_req = 1'b0; lk_ea = '0; lk_pid = '0; lk_acc = '0; lk_super = 1'b0;
      wr_en = 1'b0; wr_idx = '0; wr_valid = 1'b0; wr_pid = '0; wr_size = '0;
      wr_epn = '0; wr_rpn = '0; wr_perm = '0; wr_attr = '0; inv_all = 1'b0;
      for (int e = 0; e < 32; e++) m_write(e, 1'b0, 8'd0, 4'd0, 20'd0, 20'd0, 6'd0, 5'd0);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      @(negedge clk);
      check_idle("R1");
      do_look(32'h0000_0000, 8'd0, 2'd0, 1'b1, "R1");
      do_look(32'hFFFF_F123, 8'd3, 2'd2, 1'b0, "R1");
      // R6: no request gives quiet outputs
      @(negedge clk);
      check_idle("R6");

      // R3 R4 R9 R11: every size code, probes inside, just above and far above the page
      for (int s = 0; s < 16; s++) begin
         do_write(5, 1'b1, 8'd0, 4'(s), 20'h5A5A5, 20'h3C3C3, 6'h3F, 5'(s + 7));
         pl = (s >= 1 && s <= 9) ? 12 + 2 * (s - 1) : 12;
         base = {20'h5A5A5, 12'h000};
         ea_in  = base | ((32'd1 << pl) - 32'd1);
         ea_out = base ^ (32'd1 << pl);
         ea_hi  = base ^ 32'h8000_0000;
         do_look(base,   8'd1, 2'd0, 1'b0, "R3");
         do_look(ea_in,  8'd1, 2'd1, 1'b1, "R4");
         do_look(ea_out, 8'd1, 2'd0, 1'b0, "R3");
         do_look(ea_hi,  8'd1, 2'd0, 1'b0, "R9");
         do_write(5, 1'b0, 8'd0, 4'(s), 20'h5A5A5, 20'h3C3C3, 6'h3F, 5'(s + 7));
         do_look(base, 8'd1, 2'd0, 1'b0, "R11");
      end

      // R5: process numbers
      do_write(7, 1'b1, 8'h2A, 4'd2, 20'h04004, 20'h0ABC0, 6'h24, 5'h11);
      do_look(32'h0400_4567, 8'h2A, 2'd0, 1'b0, "R5");
      do_look(32'h0400_4567, 8'h2B, 2'd0, 1'b0, "R5");
      do_look(32'h0400_4567, 8'h00, 2'd0, 1'b0, "R5");
      do_write(7, 1'b1, 8'h00, 4'd2, 20'h04004, 20'h0ABC0, 6'h24, 5'h11);
      do_look(32'h0400_7FFF, 8'h99, 2'd0, 1'b0, "R5");

      // R7: overlapping slots, lowest index wins
      do_write(3,  1'b1, 8'd0, 4'd1, 20'h12345, 20'hAAAAA, 6'h07, 5'h01);
      do_write(9,  1'b1, 8'd0, 4'd5, 20'h12300, 20'hBBB00, 6'h38, 5'h02);
      do_write(20, 1'b1, 8'd0, 4'd1, 20'h12345, 20'hCCCCC, 6'h00, 5'h03);
      do_look(32'h1234_5ABC, 8'd4, 2'd0, 1'b0, "R7");
      do_look(32'h1230_0010, 8'd4, 2'd0, 1'b1, "R7");
      do_write(3, 1'b0, 8'd0, 4'd1, 20'h12345, 20'hAAAAA, 6'h07, 5'h01);
      do_look(32'h1234_5ABC, 8'd4, 2'd2, 1'b1, "R7");
      do_write(9, 1'b0, 8'd0, 4'd5, 20'h12300, 20'hBBB00, 6'h38, 5'h02);
      do_look(32'h1234_5ABC, 8'd4, 2'd1, 1'b0, "R7");

      // R8: every permission pattern against every access kind and privilege
      for (int p = 0; p < 64; p++) begin
         do_write(0, 1'b1, 8'd0, 4'd1, 20'h77000, 20'h01234, 6'(p), 5'h15);
         for (int a = 0; a < 4; a++)
            for (int sp = 0; sp < 2; sp++)
               do_look(32'h7700_0ABC, 8'd0, 2'(a), 1'(sp), "R8");
      end

      // R2: write and lookup in the same cycle, lookup sees old contents
      @(negedge clk);
      drive_write(11, 1'b1, 8'd0, 4'd3, 20'h66660, 20'h11110, 6'h3F, 5'h09);
      lk_req = 1'b1; lk_ea = 32'h6666_0123; lk_pid = 8'd0; lk_acc = 2'd0; lk_super = 1'b1;
      model_look(32'h6666_0123, 8'd0, 2'd0, 1'b1, h, mh, ra, pm, at, vi);
      @(negedge clk);
      wr_en = 1'b0; lk_req = 1'b0;
      compare("R2", h, mh, ra, pm, at, vi);
      m_write(11, 1'b1, 8'd0, 4'd3, 20'h66660, 20'h11110, 6'h3F, 5'h09);
      do_look(32'h6666_F123, 8'd0, 2'd0, 1'b1, "R2");

      // R2 R4: fill every slot with its own page
      for (int i = 0; i < 32; i++)
         do_write(i, 1'b1, 8'd0, 4'd1, 20'h80000 + 20'(i * 16), 20'h00100 + 20'(i * 7), 6'h3F, 5'(i));
      for (int i = 0; i < 32; i++)
         do_look({20'h80000 + 20'(i * 16), 12'hF0F}, 8'd5, 2'd0, 1'b0, "R2");

      // R10: flush together with a valid write
      @(negedge clk);
      inv_all = 1'b1;
      drive_write(2, 1'b1, 8'd0, 4'd9, 20'h00000, 20'h00000, 6'h3F, 5'h1F);
      @(negedge clk);
      inv_all = 1'b0; wr_en = 1'b0;
      m_write(2, 1'b1, 8'd0, 4'd9, 20'h00000, 20'h00000, 6'h3F, 5'h1F);
      for (int e = 0; e < 32; e++) m_valid[e] = 1'b0;
      do_look(32'h0000_1000, 8'd0, 2'd0, 1'b1, "R10");
      do_look({20'h80000, 12'h000}, 8'd0, 2'd0, 1'b1, "R10");
      do_look({20'h80000 + 20'(31 * 16), 12'h000}, 8'd0, 2'd0, 1'b1, "R10");

      // R1: reset drops installed slots
      do_write(4, 1'b1, 8'd0, 4'd9, 20'h40000, 20'h90000, 6'h3F, 5'h04);
      do_look(32'h4123_4567, 8'd0, 2'd0, 1'b0, "R1");
      do_reset();
      @(negedge clk);
      check_idle("R1");
      do_look(32'h4123_4567, 8'd0, 2'd0, 1'b0, "R1");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule